// File: doc/BRIEF.md
# Full-Map MESI Home Directory

This block is the home node of a shared-memory system with a few private caches. It holds one entry for each memory block. An entry records the block's coherence state (Invalid, Shared, Exclusive or Modified) and a presence vector with one bit for each cache.

Caches send read, read-for-ownership and writeback requests on per-port request lines and get a one-cycle response pulse back. Before it grants an access, the directory downgrades or invalidates the other holders through a snoop pulse and collects their acknowledgements. A dirty acknowledgement carries the line data. The directory writes that data back to memory and then forwards it to the requester. Otherwise the directory fetches the line from memory over a held request/ready port.

Caches may drop clean lines without telling the directory. The presence vector can therefore name caches that no longer hold the block. Such caches still answer snoops, with a clean acknowledgement. The directory runs one transaction at a time. Any request that it cannot take in a given cycle is answered with a retry, and the cache sends it again later.

Top module: `mesi_dir`

## Requirements
- R1: After reset every entry is Invalid with no presence bits, and no response, snoop or memory request is active until a request arrives.
- R2: A read (op code 2'b00) to an Invalid block reads memory at that address and answers the requester with grant-Exclusive (kind 3'd2) carrying the memory data; the entry then holds only the requester.
- R3: A read to a Shared block reads memory, answers grant-Shared (kind 3'd1) with the memory data, adds the requester's presence bit and sends no snoop.
- R4: A read to a block held Exclusive or Modified by another cache sends a downgrade snoop (snp_inv low) to that owner only. If the acknowledgement is dirty, its data is first written to memory and then returned with grant-Shared. If it is clean, memory is read instead. Both caches stay recorded as holders.
- R5: A read-for-ownership (op code 2'b01) sends one invalidating snoop pulse (snp_inv high) to every recorded holder except the requester. Only after all of them have acknowledged does it answer grant-Modified (kind 3'd3), after which only the requester is recorded.
- R6: A read-for-ownership with no other recorded holder sends no snoop, reads memory and answers grant-Modified.
- R7: An acknowledgement from a cache that is not being waited on is ignored. A clean acknowledgement from a cache that silently dropped the line counts as a completed acknowledgement.
- R8: While a transaction is open, every new request on any port is answered with retry (kind 3'd4) and leaves the directory entries unchanged.
- R9: When several idle-time requests arrive in the same cycle, the lowest-numbered port is served and every other port is answered with retry in the same cycle.
- R10: A writeback (op code 2'b10) from the single Modified owner writes its data to memory, answers writeback-done (kind 3'd5) and returns the entry to Invalid.
- R11: A writeback from a cache that is not the Modified owner is answered with writeback-done without any memory access, and the entry is left unchanged.
- R12: The reserved op code 2'b11 is answered with retry and causes no memory access or snoop.
- R13: An entry written as Exclusive or Modified has exactly one presence bit, an entry written as Invalid has none, and at most one non-retry response is issued per cycle.
- R14: A memory request holds its address, direction and write data stable until mem_ready, and it is dropped in the cycle after mem_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N | One-cycle request pulse per cache port |
| req_op | input | 2*N | Request op per port: 00 read, 01 read-for-ownership, 10 writeback, 11 reserved |
| req_addr | input | AW*N | Block address per port |
| req_data | input | DW*N | Writeback data per port |
| rsp_valid | output | N | One-cycle response pulse per port |
| rsp_kind | output | 3*N | Response kind per port: 1 Shared, 2 Exclusive, 3 Modified, 4 retry, 5 writeback-done |
| rsp_data | output | DW | Line data of the granted response |
| snp_valid | output | N | Snoop pulse per cache |
| snp_inv | output | 1 | Snoop kind: high invalidate, low downgrade |
| snp_addr | output | AW | Snooped block address |
| ack_valid | input | N | Snoop acknowledgement pulse per cache |
| ack_dirty | input | N | Acknowledgement carries modified data |
| ack_data | input | DW*N | Line data carried by a dirty acknowledgement |
| mem_valid | output | 1 | Memory request, held until mem_ready |
| mem_write | output | 1 | Memory request direction, high for write |
| mem_addr | output | AW | Memory block address |
| mem_wdata | output | DW | Memory write data |
| mem_ready | input | 1 | Memory completion pulse |
| mem_rdata | input | DW | Memory read data, valid with mem_ready |

## Verification
The bench sweeps first reads across every block and then drives every transition out of each state. A design that did not check ownership would grant Exclusive where Shared is due, or would snoop caches that hold nothing. The bench injects an acknowledgement from a cache that is not being waited on while a dirty owner is still answering. A design that counted that acknowledgement would grant early with stale memory data instead of the owner's data. The bench also issues requests during an open transaction, simultaneous requests, stale writebacks and the reserved op code. A design without the busy check, the priority or the ownership test would then grant twice, corrupt the presence vector, or write stale data to memory, and a later snoop mask exposes the damage.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} dstate_t;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_RFO = 2'd1, OP_WB = 2'd2, OP_RSV = 2'd3} op_t;
  typedef enum logic [2:0] {
    RK_NONE = 3'd0, RK_S = 3'd1, RK_E = 3'd2, RK_M = 3'd3, RK_RETRY = 3'd4, RK_WBACK = 3'd5
  } rkind_t;
  typedef enum logic [1:0] {F_IDLE = 2'd0, F_SNOOP = 2'd1, F_MRD = 2'd2, F_MWR = 2'd3} fsm_t;
endpackage

// File: rtl/dir_arbiter.sv
module dir_arbiter #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
      end
    end
    any = |req;
  end
endmodule

// File: rtl/dir_store.sv
module dir_store
  import coh_pkg::*;
#(
  parameter int N    = 4,
  parameter int NBLK = 16,
  parameter int AW   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  output dstate_t       rd_st,
  output logic [N-1:0]  rd_pv,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  dstate_t       wr_st,
  input  logic [N-1:0]  wr_pv
);
  dstate_t        st_mem [NBLK];
  logic [N-1:0]   pv_mem [NBLK];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBLK; b++) begin
        st_mem[b] <= ST_I;
        pv_mem[b] <= '0;
      end
    end else if (we) begin
      st_mem[wr_addr] <= wr_st;
      pv_mem[wr_addr] <= wr_pv;
    end
  end

  assign rd_st = st_mem[rd_addr];
  assign rd_pv = pv_mem[rd_addr];
endmodule

// File: rtl/mesi_dir.sv
module mesi_dir
  import coh_pkg::*;
#(
  parameter int N    = 4,
  parameter int NBLK = 16,
  parameter int DW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      req_valid,
  input  logic [2*N-1:0]    req_op,
  input  logic [AW*N-1:0]   req_addr,
  input  logic [DW*N-1:0]   req_data,
  output logic [N-1:0]      rsp_valid,
  output logic [3*N-1:0]    rsp_kind,
  output logic [DW-1:0]     rsp_data,
  output logic [N-1:0]      snp_valid,
  output logic              snp_inv,
  output logic [AW-1:0]     snp_addr,
  input  logic [N-1:0]      ack_valid,
  input  logic [N-1:0]      ack_dirty,
  input  logic [DW*N-1:0]   ack_data,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ready,
  input  logic [DW-1:0]     mem_rdata
);
  localparam int AW = $clog2(NBLK);
  localparam int IW = $clog2(N);

  fsm_t          fsm_q;
  logic [IW-1:0] cur_idx_q;
  logic [AW-1:0] cur_addr_q;
  dstate_t       fin_st_q;
  logic [N-1:0]  fin_pv_q;
  rkind_t        fin_kind_q;
  logic [N-1:0]  pend_q;
  logic          dirty_q;
  logic [DW-1:0] hold_q;

  logic [N-1:0]  gnt;
  logic [IW-1:0] w_idx;
  logic          w_any;
  op_t           w_op;
  logic [AW-1:0] w_addr;
  logic [DW-1:0] w_data;
  logic [N-1:0]  reqbit, others;
  dstate_t       rd_st;
  logic [N-1:0]  rd_pv;

  logic          ent_we;
  dstate_t       ent_wst;
  logic [N-1:0]  ent_wpv;

  logic [N-1:0]  ack_hit, pend_n;
  logic          dhit;
  logic [DW-1:0] data_n;

  dir_arbiter #(.N(N), .IW(IW)) arb_i (
    .req(req_valid), .gnt(gnt), .idx(w_idx), .any(w_any)
  );

  always_comb begin
    w_op   = op_t'(req_op[{w_idx, 1'b0} +: 2]);
    w_addr = req_addr[w_idx*AW +: AW];
    w_data = req_data[w_idx*DW +: DW];
    reqbit = '0;
    reqbit[w_idx] = 1'b1;
    others = rd_pv & ~reqbit;
  end

  dir_store #(.N(N), .NBLK(NBLK), .AW(AW)) store_i (
    .clk(clk), .rst(rst),
    .rd_addr(w_addr), .rd_st(rd_st), .rd_pv(rd_pv),
    .we(ent_we), .wr_addr(cur_addr_q), .wr_st(ent_wst), .wr_pv(ent_wpv)
  );

  // entry update coincides with the final response
  assign ent_we  = (fsm_q == F_MRD || fsm_q == F_MWR) && mem_ready;
  assign ent_wst = fin_st_q;
  assign ent_wpv = fin_pv_q;

  // acknowledgement merge: only waited-on caches count
  always_comb begin
    ack_hit = ack_valid & pend_q;
    pend_n  = pend_q & ~ack_valid;
    dhit    = 1'b0;
    data_n  = hold_q;
    for (int i = 0; i < N; i++) begin
      if (ack_hit[i] && ack_dirty[i]) begin
        dhit   = 1'b1;
        data_n = ack_data[i*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q      <= F_IDLE;
      cur_idx_q  <= '0;
      cur_addr_q <= '0;
      fin_st_q   <= ST_I;
      fin_pv_q   <= '0;
      fin_kind_q <= RK_NONE;
      pend_q     <= '0;
      dirty_q    <= 1'b0;
      hold_q     <= '0;
      rsp_valid  <= '0;
      rsp_kind   <= '0;
      rsp_data   <= '0;
      snp_valid  <= '0;
      snp_inv    <= 1'b0;
      snp_addr   <= '0;
      mem_valid  <= 1'b0;
      mem_write  <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      rsp_valid <= '0;
      rsp_kind  <= '0;
      snp_valid <= '0;
      for (int i = 0; i < N; i++) begin
        if (req_valid[i] && (fsm_q != F_IDLE || !gnt[i])) begin
          rsp_valid[i]       <= 1'b1;
          rsp_kind[3*i +: 3] <= RK_RETRY;
        end
      end
      case (fsm_q)
        F_IDLE: begin
          if (w_any) begin
            cur_idx_q  <= w_idx;
            cur_addr_q <= w_addr;
            dirty_q    <= 1'b0;
            pend_q     <= others;
            case (w_op)
              OP_WB: begin
                if (rd_st == ST_M && rd_pv == reqbit) begin
                  fin_st_q   <= ST_I;
                  fin_pv_q   <= '0;
                  fin_kind_q <= RK_WBACK;
                  hold_q     <= w_data;
                  mem_valid  <= 1'b1;
                  mem_write  <= 1'b1;
                  mem_addr   <= w_addr;
                  mem_wdata  <= w_data;
                  fsm_q      <= F_MWR;
                end else begin
                  rsp_valid[w_idx]       <= 1'b1;
                  rsp_kind[w_idx*3 +: 3] <= RK_WBACK;
                end
              end
              OP_RD: begin
                if ((rd_st == ST_E || rd_st == ST_M) && others != '0) begin
                  fin_st_q   <= ST_S;
                  fin_pv_q   <= others | reqbit;
                  fin_kind_q <= RK_S;
                  snp_valid  <= others;
                  snp_inv    <= 1'b0;
                  snp_addr   <= w_addr;
                  fsm_q      <= F_SNOOP;
                end else begin
                  fin_st_q   <= (rd_st == ST_S) ? ST_S : ST_E;
                  fin_pv_q   <= (rd_st == ST_S) ? (rd_pv | reqbit) : reqbit;
                  fin_kind_q <= (rd_st == ST_S) ? RK_S : RK_E;
                  mem_valid  <= 1'b1;
                  mem_write  <= 1'b0;
                  mem_addr   <= w_addr;
                  fsm_q      <= F_MRD;
                end
              end
              OP_RFO: begin
                fin_st_q   <= ST_M;
                fin_pv_q   <= reqbit;
                fin_kind_q <= RK_M;
                if (others != '0) begin
                  snp_valid <= others;
                  snp_inv   <= 1'b1;
                  snp_addr  <= w_addr;
                  fsm_q     <= F_SNOOP;
                end else begin
                  mem_valid <= 1'b1;
                  mem_write <= 1'b0;
                  mem_addr  <= w_addr;
                  fsm_q     <= F_MRD;
                end
              end
              default: begin
                rsp_valid[w_idx]       <= 1'b1;
                rsp_kind[w_idx*3 +: 3] <= RK_RETRY;
              end
            endcase
          end
        end
        F_SNOOP: begin
          pend_q  <= pend_n;
          dirty_q <= dirty_q | dhit;
          hold_q  <= data_n;
          if (pend_n == '0) begin
            mem_valid <= 1'b1;
            mem_addr  <= cur_addr_q;
            mem_write <= dirty_q | dhit;
            mem_wdata <= data_n;
            fsm_q     <= (dirty_q | dhit) ? F_MWR : F_MRD;
          end
        end
        default: begin
          if (mem_ready) begin
            mem_valid                  <= 1'b0;
            rsp_valid[cur_idx_q]       <= 1'b1;
            rsp_kind[cur_idx_q*3 +: 3] <= fin_kind_q;
            rsp_data                   <= (fsm_q == F_MRD) ? mem_rdata : hold_q;
            fsm_q                      <= F_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mesi_dir_chk.sv
module mesi_dir_chk #(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  rsp_valid,
  input logic [3*N-1:0] rsp_kind,
  input logic [N-1:0]  snp_valid,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          ent_we,
  input logic [1:0]    ent_wst,
  input logic [N-1:0]  ent_wpv
);
  logic [N-1:0] gvec;
  always_comb begin
    for (int i = 0; i < N; i++) gvec[i] = rsp_valid[i] && (rsp_kind[3*i +: 3] != 3'd4);
  end

  a_r13_owner_single: assert property (@(posedge clk) disable iff (rst)
    (ent_we && ent_wst[1]) |-> ($countones(ent_wpv) == 1));
  a_r13_invalid_empty: assert property (@(posedge clk) disable iff (rst)
    (ent_we && ent_wst == 2'd0) |-> (ent_wpv == '0));
  a_r13_one_grant: assert property (@(posedge clk) disable iff (rst)
    $countones(gvec) <= 1);
  a_r14_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));
  a_r14_mem_drop: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready) |=> !mem_valid);
  a_r5_snoop_pulse: assert property (@(posedge clk) disable iff (rst)
    (|snp_valid) |=> !(|snp_valid));
endmodule

bind mesi_dir mesi_dir_chk #(.N(N), .DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
  .snp_valid(snp_valid), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .ent_we(ent_we), .ent_wst(ent_wst), .ent_wpv(ent_wpv)
);

// File: tb/mesi_dir_tb_top.sv
module mesi_dir_tb_top;
  localparam int N = 4, NBLK = 16, DW = 8, AW = 4;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic [N-1:0] req_valid = '0;
  logic [2*N-1:0] req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [DW*N-1:0] req_data = '0;
  logic [N-1:0] rsp_valid, snp_valid;
  logic [3*N-1:0] rsp_kind;
  logic [DW-1:0] rsp_data, mem_wdata, mem_rdata;
  logic snp_inv, mem_valid, mem_write, mem_ready;
  logic [AW-1:0] snp_addr, mem_addr;
  logic [N-1:0] rack = '0, inj = '0, rdirty = '0;
  logic [DW*N-1:0] rdata = '0;
  logic mrdy = 1'b0;
  logic [DW-1:0] mrd = '0;

  assign mem_ready = mrdy;
  assign mem_rdata = mrd;

  mesi_dir #(.N(N), .NBLK(NBLK), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
    .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_addr(snp_addr),
    .ack_valid(rack | inj), .ack_dirty(rdirty), .ack_data(rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  int errs = 0, checks = 0;
  bit done = 0;
  logic [DW-1:0] mem [NBLK];
  bit cdirty [N][NBLK];
  logic [DW-1:0] cdata [N][NBLK];
  int sdly [N];
  logic [AW-1:0] sadr [N];
  logic [N-1:0] snp_log = '0;
  logic inv_log = 1'b0;
  int nrd = 0, nwr = 0, hold_err = 0;
  logic [AW-1:0] wa_log = '0;
  logic [DW-1:0] wd_log = '0;
  bit got [N];
  int gk [N];
  int gd [N];
  bit mbusy = 0;
  int mcnt = 0;
  logic [AW-1:0] ma_q = '0;
  logic mw_q = 1'b0;

  function automatic logic [DW-1:0] f(input int a);
    return DW'(a * 7 + 3);
  endfunction

  task automatic check_eq(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // cache snoop responders: cache c answers c+1 cycles after a snoop
  always @(negedge clk) begin
    for (int c = 0; c < N; c++) begin
      rack[c] = 1'b0;
      if (sdly[c] > 0) begin
        sdly[c]--;
        if (sdly[c] == 0) begin
          rack[c] = 1'b1;
          rdirty[c] = cdirty[c][sadr[c]];
          rdata[c*DW +: DW] = cdata[c][sadr[c]];
          cdirty[c][sadr[c]] = 0;
        end
      end
      if (snp_valid[c]) begin
        sdly[c] = c + 1;
        sadr[c] = snp_addr;
        snp_log[c] = 1'b1;
        inv_log = snp_inv;
      end
      if (rsp_valid[c]) begin
        got[c] = 1;
        gk[c] = int'(rsp_kind[3*c +: 3]);
        gd[c] = int'(rsp_data);
      end
    end
  end

  // memory model, two cycles of latency
  always @(negedge clk) begin
    if (mrdy) mrdy = 1'b0;
    else if (mbusy) begin
      if (mem_addr != ma_q || mem_write != mw_q || !mem_valid) hold_err++;
      mcnt--;
      if (mcnt == 0) begin
        mrdy = 1'b1;
        mbusy = 0;
        if (mw_q) begin
          mem[ma_q] = mem_wdata; nwr++; wa_log = ma_q; wd_log = mem_wdata;
        end else begin
          mrd = mem[ma_q]; nrd++;
        end
      end
    end else if (mem_valid) begin
      mbusy = 1; mcnt = 2; ma_q = mem_addr; mw_q = mem_write;
    end
  end

  task automatic clear_log();
    snp_log = '0; inv_log = 1'b0; nrd = 0; nwr = 0;
    for (int c = 0; c < N; c++) got[c] = 0;
  endtask

  task automatic drive(input int c, input int op, input int a, input int d);
    req_valid[c] = 1'b1;
    req_op[2*c +: 2] = 2'(op);
    req_addr[AW*c +: AW] = AW'(a);
    req_data[DW*c +: DW] = DW'(d);
  endtask

  task automatic send(input int c, input int op, input int a, input int d);
    @(negedge clk);
    drive(c, op, a, d);
    @(negedge clk);
    req_valid = '0;
  endtask

  task automatic wait_rsp(input int c, output int k, output int d);
    int t = 0;
    while (!got[c] && t < 300) begin @(negedge clk); t++; end
    if (!got[c]) begin
      errs++; checks++;
      $display("FAIL response timeout port %0d actual=0 expected=1", c);
    end
    got[c] = 0;
    k = gk[c];
    d = gd[c];
  endtask

  task automatic tx(input int c, input int op, input int a, input int d, output int k, output int dd);
    clear_log();
    send(c, op, a, d);
    wait_rsp(c, k, dd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int k, d;
    for (int a = 0; a < NBLK; a++) mem[a] = f(a);
    for (int c = 0; c < N; c++) begin
      sdly[c] = 0;
      for (int a = 0; a < NBLK; a++) begin cdirty[c][a] = 0; cdata[c][a] = '0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    check_eq("R1 rsp_valid", int'(rsp_valid), 0);
    check_eq("R1 snp_valid", int'(snp_valid), 0);
    check_eq("R1 mem_valid", int'(mem_valid), 0);
    // R2 sweep: first reads grant Exclusive with memory data
    for (int a = 0; a < NBLK; a++) begin
      tx(a % N, 0, a, 0, k, d);
      check_eq("R2 kind", k, 2);
      check_eq("R2 data", d, int'(f(a)));
      check_eq("R1 no snoop on fresh block", int'(snp_log), 0);
    end
    // R4 clean owner: block 0 owned E by cache 0
    tx(1, 0, 0, 0, k, d);
    check_eq("R4 snoop mask", int'(snp_log), 1);
    check_eq("R4 downgrade kind", int'(inv_log), 0);
    check_eq("R4 kind", k, 1);
    check_eq("R4 clean data", d, int'(f(0)));
    check_eq("R4 clean no write", nwr, 0);
    // R3 read to Shared
    tx(2, 0, 0, 0, k, d);
    check_eq("R3 kind", k, 1);
    check_eq("R3 no snoop", int'(snp_log), 0);
    check_eq("R3 data", d, int'(f(0)));
    // R5 read-for-ownership with sharers (cache 1 has silently dropped: clean ack, R7)
    tx(3, 1, 0, 0, k, d);
    check_eq("R5 snoop mask", int'(snp_log), 7);
    check_eq("R5 invalidate", int'(inv_log), 1);
    check_eq("R5 kind", k, 3);
    check_eq("R7 data after clean acks", d, int'(f(0)));
    cdirty[3][0] = 1; cdata[3][0] = 8'hA5;
    // R4 dirty owner
    tx(0, 0, 0, 0, k, d);
    check_eq("R4 dirty snoop mask", int'(snp_log), 8);
    check_eq("R4 dirty writes", nwr, 1);
    check_eq("R4 dirty write data", int'(wd_log), 'hA5);
    check_eq("R4 dirty grant data", d, 'hA5);
    check_eq("R4 dirty kind", k, 1);
    // R7 stale acknowledgement while the dirty owner is still answering
    cdirty[1][1] = 1; cdata[1][1] = 8'h3C;
    clear_log();
    send(0, 1, 1, 0);
    inj[2] = 1'b1;
    @(negedge clk) inj = '0;
    wait_rsp(0, k, d);
    check_eq("R7 grant data from owner", d, 'h3C);
    check_eq("R7 kind", k, 3);
    check_eq("R5 snoop mask single", int'(snp_log), 2);
    cdirty[0][1] = 1; cdata[0][1] = 8'h77;
    // R8 busy: block 3 owned E by cache 3
    clear_log();
    send(2, 1, 3, 0);
    @(negedge clk);
    drive(0, 0, 3, 0);
    drive(1, 0, 5, 0);
    @(negedge clk) req_valid = '0;
    wait_rsp(0, k, d);
    check_eq("R8 retry same block", k, 4);
    wait_rsp(1, k, d);
    check_eq("R8 retry other block", k, 4);
    wait_rsp(2, k, d);
    check_eq("R8 owner grant", k, 3);
    check_eq("R8 owner data", d, int'(f(3)));
    tx(0, 0, 3, 0, k, d);
    check_eq("R13 single owner snooped", int'(snp_log), 4);
    check_eq("R8 read after busy", k, 1);
    // R9 simultaneous requests, block 6 owned E by cache 2
    clear_log();
    @(negedge clk);
    drive(3, 0, 6, 0);
    drive(1, 0, 6, 0);
    @(negedge clk) req_valid = '0;
    wait_rsp(3, k, d);
    check_eq("R9 loser retry", k, 4);
    wait_rsp(1, k, d);
    check_eq("R9 winner kind", k, 1);
    check_eq("R9 winner data", d, int'(f(6)));
    // R10 writeback from Modified owner
    tx(0, 2, 1, 'h77, k, d);
    check_eq("R10 kind", k, 5);
    check_eq("R10 writes", nwr, 1);
    check_eq("R10 write addr", int'(wa_log), 1);
    check_eq("R10 write data", int'(wd_log), 'h77);
    cdirty[0][1] = 0;
    tx(2, 0, 1, 0, k, d);
    check_eq("R10 entry invalid then E", k, 2);
    check_eq("R10 memory data", d, 'h77);
    // R11 stale writeback
    tx(3, 2, 1, 'hEE, k, d);
    check_eq("R11 kind", k, 5);
    check_eq("R11 no memory access", nwr + nrd, 0);
    tx(3, 1, 1, 0, k, d);
    check_eq("R11 owner unchanged", int'(snp_log), 4);
    check_eq("R11 data kept", d, 'h77);
    // R6 read-for-ownership with no other holder, block 2 owned E by cache 2
    tx(2, 1, 2, 0, k, d);
    check_eq("R6 no snoop", int'(snp_log), 0);
    check_eq("R6 kind", k, 3);
    check_eq("R6 data", d, int'(f(2)));
    check_eq("R6 reads", nrd, 1);
    // R12 reserved op
    tx(1, 3, 4, 0, k, d);
    check_eq("R12 retry", k, 4);
    check_eq("R12 no memory access", nrd + nwr, 0);
    check_eq("R12 no snoop", int'(snp_log), 0);
    tx(0, 0, 4, 0, k, d);
    check_eq("R12 entry unchanged", k, 2);
    // R14 memory request stability over the whole run
    check_eq("R14 hold violations", hold_err, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule